// File: doc/BRIEF.md
# CDR Lock Supervisor

This block is the digital supervisory logic that sits around a clock-recovery PLL for SONET/SDH line rates. It compares the frequency of the recovered VCO clock with a 19.44 MHz reference. The comparison is a count of VCO cycles across a fixed window of reference cycles, checked against a ppm band that scales with the selected line rate. From that result and the control pins it produces a lock indication, clamps the retimed data during loss of signal, and chooses what drives the clock output.

In normal use `bypass` is low and `sts12` selects the line rate: a VCO ratio of 32 for the 622.08 MHz rate and 8 for the 155.52 MHz rate. An optical receiver's signal-detect output drives `sd`, and a system controller can pull `lock_refn` low to force the loop onto the reference. Setting `bypass` with `sts12` high is a test mode: the inverted reference reaches `clk_out` and raw `data_in` reaches `data_out`. Setting `bypass` with `sts12` low is illegal. In that case `cfg_err` is raised and the block otherwise works as in normal mode.

Top module: `cdr_supervisor`

## Requirements
- R1: While `rst_n` is low and after its release, `lock_det` is low. `data_out` is low until the first VCO falling edge after reset.
- R2: `cfg_err` is high exactly when `bypass` is 1 and `sts12` is 0. In that case clock, data and lock behave as they do with `bypass` at 0.
- R3: In normal mode (bypass test mode inactive, `sd`=1, `lock_refn`=1), `clk_out` follows `vco_clk`. `data_out` is `data_in` sampled on the falling edge of `vco_clk`, so it stays stable around each rising edge of `clk_out`.
- R4: When the bypass test mode is inactive and `sd`=0 or `lock_refn`=0, `data_out` is held at 0 and `clk_out` still follows `vco_clk`.
- R5: With `bypass`=1 and `sts12`=1, `clk_out` is the inverse of `ref_clk` and `data_out` equals `data_in` with no register in the path.
- R6: `lock_det` is low in the same instant that `sd` or `lock_refn` is 0. Otherwise it equals the held frequency verdict. The `bypass` pin does not affect it.
- R7: Each window spans 2^WIN_LOG2 `ref_clk` cycles. The VCO count in a window is in range when it lies within TOL×ratio of 2^WIN_LOG2×ratio, where the ratio is 32 when `sts12`=1 and 8 when `sts12`=0.
- R8: The frequency verdict becomes good only after two consecutive in-range window results.
- R9: A single out-of-range window result clears the frequency verdict.
- R10: If `vco_clk` stops so that three window ends pass with no result, the frequency verdict is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ref_clk | input | 1 | 19.44 MHz reference clock |
| vco_clk | input | 1 | Recovered VCO clock |
| data_in | input | 1 | Serial NRZ line data |
| sts12 | input | 1 | Line-rate select: 1 = ratio 32, 0 = ratio 8 |
| bypass | input | 1 | Test bypass request |
| lock_refn | input | 1 | Active-low force onto reference |
| sd | input | 1 | Signal detect from the optical receiver |
| data_out | output | 1 | Retimed, clamped or bypassed data |
| clk_out | output | 1 | VCO clock, or inverted reference in bypass |
| lock_det | output | 1 | High when the frequency is locked and the signal is valid |
| cfg_err | output | 1 | Illegal bypass configuration flag |

## Verification
The assertions check on every cycle that the data clamp holds during loss of signal, that the forcing inputs pull `lock_det` low, that the verdict rises only on the second in-range result, and that an out-of-range result or a run of missing results clears it. Only the bench scenarios can show that the window count tracks real VCO periods: near-nominal periods lock, periods a few percent off unlock, and the scaling follows `sts12`. The same holds for the launch of retimed data on the VCO falling edge and for the clock-output source. The bench sweeps every control-pin combination in both rate modes and checks clock-edge counts and data against values it computes itself.

// File: rtl/cdr_supervisor.sv
`timescale 1ps/1ps
module cdr_supervisor #(
  parameter int WIN_LOG2 = 14,
  parameter int TOL      = 8,
  parameter int HI_SHIFT = 5,
  parameter int LO_SHIFT = 3,
  parameter int MISS_LIM = 3
) (
  input  logic rst_n,
  input  logic ref_clk,
  input  logic vco_clk,
  input  logic data_in,
  input  logic sts12,
  input  logic bypass,
  input  logic lock_refn,
  input  logic sd,
  output logic data_out,
  output logic clk_out,
  output logic lock_det,
  output logic cfg_err
);
  localparam int CW = WIN_LOG2 + HI_SHIFT + 2;
  localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] NOM_HI = ONE << (WIN_LOG2 + HI_SHIFT);
  localparam logic [CW-1:0] NOM_LO = ONE << (WIN_LOG2 + LO_SHIFT);
  localparam logic [CW-1:0] TOL_HI = CW'(TOL) << HI_SHIFT;
  localparam logic [CW-1:0] TOL_LO = CW'(TOL) << LO_SHIFT;
  localparam logic [1:0]    MISS_MAX = 2'(MISS_LIM);

  // reference domain
  logic [WIN_LOG2-1:0] win_cnt;
  logic                win_tgl;
  logic [2:0]          ack_s;
  logic [1:0]          miss;
  logic                good1, freq_ok;
  // VCO domain
  logic [2:0]          tgl_s;
  logic [CW-1:0]       vcnt, cap;
  logic                primed, ack_tgl, d_q;

  wire win_end = &win_cnt;
  wire res_stb = ack_s[2] ^ ack_s[1];
  wire vedge   = tgl_s[2] ^ tgl_s[1];
  wire byp_act = bypass & sts12;
  wire los     = ~byp_act & (~sd | ~lock_refn);

  wire [CW-1:0] nom  = sts12 ? NOM_HI : NOM_LO;
  wire [CW-1:0] tolw = sts12 ? TOL_HI : TOL_LO;
  wire [CW-1:0] diff = (cap >= nom) ? cap - nom : nom - cap;
  wire in_range = diff <= tolw;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      win_tgl <= 1'b0;
      ack_s   <= '0;
      miss    <= '0;
      good1   <= 1'b0;
      freq_ok <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      ack_s   <= {ack_s[1:0], ack_tgl};
      if (win_end) win_tgl <= ~win_tgl;
      if (miss == MISS_MAX) begin
        good1   <= 1'b0;
        freq_ok <= 1'b0;
      end
      if (res_stb) begin
        miss <= '0;
        if (in_range) begin
          good1 <= 1'b1;
          if (good1) freq_ok <= 1'b1;
        end else begin
          good1   <= 1'b0;
          freq_ok <= 1'b0;
        end
      end else if (win_end && miss != MISS_MAX) begin
        miss <= miss + 1'b1;
      end
    end

  always_ff @(posedge vco_clk or negedge rst_n)
    if (!rst_n) begin
      tgl_s   <= '0;
      vcnt    <= '0;
      cap     <= '0;
      primed  <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      tgl_s <= {tgl_s[1:0], win_tgl};
      if (vedge) begin
        vcnt   <= ONE;
        cap    <= vcnt;
        primed <= 1'b1;
        if (primed) ack_tgl <= ~ack_tgl;
      end else if (~&vcnt) begin
        vcnt <= vcnt + 1'b1;
      end
    end

  always_ff @(negedge vco_clk or negedge rst_n)
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= data_in;

  assign cfg_err  = bypass & ~sts12;
  assign clk_out  = byp_act ? ~ref_clk : vco_clk;
  assign data_out = byp_act ? data_in : (los ? 1'b0 : d_q);
  assign lock_det = freq_ok & sd & lock_refn;
endmodule

module cdr_supervisor_chk (
  input logic rst_n,
  input logic ref_clk,
  input logic vco_clk,
  input logic bypass,
  input logic sts12,
  input logic sd,
  input logic lock_refn,
  input logic data_out,
  input logic lock_det,
  input logic res_stb,
  input logic in_range,
  input logic good1,
  input logic freq_ok,
  input logic [1:0] miss
);
  // R4
  los_clamp_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (!(bypass && sts12) && (!sd || !lock_refn)) |-> !data_out);
  // R6
  force_unlock_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!sd || !lock_refn) |-> !lock_det);
  // R8
  two_good_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(freq_ok) |-> ($past(res_stb) && $past(good1) && $past(in_range)));
  // R9
  bad_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (res_stb && !in_range) |=> !freq_ok);
  // R10
  miss_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (miss == 2'd3 && !res_stb) |=> !freq_ok);
endmodule

bind cdr_supervisor cdr_supervisor_chk u_chk (
  .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk), .bypass(bypass),
  .sts12(sts12), .sd(sd), .lock_refn(lock_refn), .data_out(data_out),
  .lock_det(lock_det), .res_stb(res_stb), .in_range(in_range),
  .good1(good1), .freq_ok(freq_ok), .miss(miss)
);

// File: tb/cdr_supervisor_bench.sv
`timescale 1ps/1ps
module cdr_supervisor_bench;
  localparam int WL = 8;
  localparam int W  = 1 << WL;
  localparam int REF_HALF = 10000;

  logic rst_n = 0, ref_clk = 0, vco_clk = 0, data_in = 0;
  logic sts12 = 0, bypass = 0, lock_refn = 1, sd = 1;
  logic data_out, clk_out, lock_det, cfg_err;
  int vco_half = 1250;
  bit vco_run = 1;
  int n_chk = 0, n_fail = 0, clk_edges = 0;

  cdr_supervisor #(.WIN_LOG2(WL), .TOL(2)) u_cdr_supervisor (
    .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk), .data_in(data_in),
    .sts12(sts12), .bypass(bypass), .lock_refn(lock_refn), .sd(sd),
    .data_out(data_out), .clk_out(clk_out), .lock_det(lock_det), .cfg_err(cfg_err));

  always #(REF_HALF) ref_clk = ~ref_clk;
  initial forever begin #(vco_half); if (vco_run) vco_clk = ~vco_clk; end
  always @(posedge clk_out) clk_edges++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge ref_clk);
    #(REF_HALF/2);
  endtask

  // clk_out edges over n reference cycles, compared with the expected source
  task automatic clk_src(input bit inv_ref, input int n, input string req);
    int c0, got, exp;
    wait_ref(1);
    c0 = clk_edges;
    wait_ref(n);
    got = clk_edges - c0;
    exp = inv_ref ? n : (n * 2 * REF_HALF) / (2 * vco_half);
    check(got >= exp - 1 && got <= exp + 1, req, got, exp);
  endtask

  task automatic sweep_mode(input bit mode);
    for (int k = 0; k < 8; k++) begin
      bit byp, lr, s, bact, losx;
      byp = k[2]; lr = k[1]; s = k[0];
      bypass = byp; lock_refn = lr; sd = s;
      bact = byp & mode;
      losx = !bact && (!s || !lr);
      wait_ref(1);
      check(cfg_err == (byp & ~mode), "R2 cfg_err", cfg_err, byp & ~mode);
      check(lock_det == (s & lr), "R6 lock_det vs pins", lock_det, s & lr);
      for (int v = 0; v < 2; v++) begin
        data_in = v[0];
        wait_ref(2);
        if (bact)      check(data_out == v[0], "R5 direct data", data_out, v);
        else if (losx) check(data_out == 0, "R4 clamp", data_out, 0);
        else           check(data_out == v[0], "R3 retimed data", data_out, v);
      end
      clk_src(bact, 4, bact ? "R5 inverted ref clock" : (losx ? "R4 vco clock" : "R3 vco clock"));
    end
    bypass = 0; lock_refn = 1; sd = 1;
  endtask

  initial begin
    #(REF_HALF * 2 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_ref(3);
    // R1 reset state
    check(lock_det == 0, "R1 lock_det in reset", lock_det, 0);
    check(data_out == 0, "R1 data_out in reset", data_out, 0);
    rst_n = 1;
    wait_ref(W);
    check(lock_det == 0, "R1 lock_det after reset", lock_det, 0);

    // R7 ratio 8, near nominal: locks
    wait_ref(4 * W);
    check(lock_det == 1, "R7 lock at ratio 8", lock_det, 1);
    vco_half = 1255;
    wait_ref(3 * W);
    check(lock_det == 1, "R7 0.4% off still in range", lock_det, 1);

    // R9 out of range drops lock
    vco_half = 1280;
    wait_ref(3 * W);
    check(lock_det == 0, "R9 2.4% slow drops lock", lock_det, 0);
    vco_half = 1225;
    wait_ref(3 * W);
    check(lock_det == 0, "R9 2% fast stays unlocked", lock_det, 0);

    // R8 one good window is not enough
    vco_half = 1250;
    wait_ref(W - 10);
    check(lock_det == 0, "R8 no lock after one window", lock_det, 0);
    wait_ref(3 * W);
    check(lock_det == 1, "R8 lock after two good windows", lock_det, 1);

    // R6 forcing inputs act at once
    sd = 0; #100;
    check(lock_det == 0, "R6 sd low forces unlock", lock_det, 0);
    sd = 1; #100;
    check(lock_det == 1, "R6 sd back restores lock", lock_det, 1);
    lock_refn = 0; #100;
    check(lock_det == 0, "R6 lock_refn low forces unlock", lock_det, 0);
    lock_refn = 1;

    // R3 retiming on the VCO falling edge
    for (int i = 0; i < 4; i++) begin
      logic old;
      @(negedge vco_clk); #1;
      old = data_out;
      data_in = ~data_out;
      #(2 * vco_half - 20);
      check(data_out == old, "R3 data held until falling edge", data_out, old);
      @(negedge vco_clk); #1;
      check(data_out == data_in, "R3 data launched on falling edge", data_out, data_in);
    end

    sweep_mode(1'b0);

    // R10 stopped VCO clears the verdict
    vco_run = 0;
    wait_ref(5 * W);
    check(lock_det == 0, "R10 stopped vco unlocks", lock_det, 0);
    vco_run = 1;
    wait_ref(5 * W);
    check(lock_det == 1, "R10 relock after restart", lock_det, 1);

    // R7 ratio 32
    sts12 = 1;
    vco_half = 312;
    wait_ref(5 * W);
    check(lock_det == 1, "R7 lock at ratio 32", lock_det, 1);
    vco_half = 320;
    wait_ref(3 * W);
    check(lock_det == 0, "R7 2.5% off at ratio 32 unlocks", lock_det, 0);
    vco_half = 314;
    wait_ref(4 * W);
    check(lock_det == 1, "R7 0.5% off at ratio 32 locks", lock_det, 1);

    sweep_mode(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule